// File: doc/BRIEF.md
# Dual Segment Address Translator

This block turns program-generated logical addresses into physical addresses for a simple in-order pipeline, and checks each access against a segment length. There are two independent channels. The fetch channel serves instruction fetches from the program counter. The data channel serves loads and stores. Each channel has its own base register and its own limit register. The physical address is the base plus the logical address. An access whose logical address is equal to or above the limit is refused: it is flagged as a fault, and its request toward memory is withheld in the same cycle.

The four registers are programmed through a small configuration port. Privileged code can write them and read them back. A write attempted in user mode has no effect on any register, and it raises a sticky privilege-error flag that stays set until it is explicitly cleared. After reset every register is zero. Because every limit is then zero, every access faults until privileged code has set up the segments.

Top module: `seg_xlate_top`

## Requirements
- R1: Each channel's physical address output equals its base register plus its logical address input, taken modulo 2^AW. This holds on the same cycle as the input.
- R2: A channel's fault output is high exactly when its request is high and its logical address is greater than or equal to its limit register. An address equal to the limit faults. An address one below the limit does not.
- R3: A channel's valid output is high exactly when its request is high and its fault output is low, in the same cycle.
- R4: Fetch requests use only the fetch base and limit, and data requests use only the data base and limit. Both channels may be active in the same cycle without affecting each other.
- R5: A write with `cfg_we` high and `supervisor` high loads `cfg_wdata` into the register picked by `cfg_sel`. The selector encoding is 0 = fetch base, 1 = fetch limit, 2 = data base, 3 = data limit. The new value is in effect from the cycle after the write edge.
- R6: A write with `cfg_we` high and `supervisor` low changes no register. Translation results and read-back values stay as they were.
- R7: A user-mode write sets `priv_err` from the next cycle. The flag stays set until a cycle with `priv_err_clr` high. If a user-mode write and a clear happen in the same cycle, the flag is set.
- R8: `cfg_rdata` shows the register picked by `cfg_sel` while `supervisor` is high, and is zero while `supervisor` is low.
- R9: After reset all four registers read zero and `priv_err` is low. As a result, every request on either channel faults and none is valid.
- R10: With its request low, a channel drives both valid and fault low, whatever its logical address is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supervisor | input | 1 | Processor is in privileged mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector (0 fetch base, 1 fetch limit, 2 data base, 3 data limit) |
| cfg_wdata | input | AW | Register write value |
| cfg_rdata | output | AW | Selected register in privileged mode, else zero |
| priv_err_clr | input | 1 | Clears the privilege-error flag |
| priv_err | output | 1 | Sticky flag for a rejected user-mode write |
| if_req | input | 1 | Fetch request |
| if_laddr | input | AW | Fetch logical address |
| if_paddr | output | AW | Fetch physical address |
| if_valid | output | 1 | Fetch request forwarded to memory |
| if_fault | output | 1 | Fetch outside its segment |
| dm_req | input | 1 | Data request |
| dm_laddr | input | AW | Data logical address |
| dm_paddr | output | AW | Data physical address |
| dm_valid | output | 1 | Data request forwarded to memory |
| dm_fault | output | 1 | Data access outside its segment |

## Verification
The translation results (physical address, valid and fault on both channels) are combinational. They are due in the same cycle as the request, so the bench drives them on a falling edge and samples them one nanosecond later. A register write or a user-mode write is captured on the next rising edge. Its effect, whether a new translation, a new read-back value or a set `priv_err`, is therefore due one cycle after the write is presented. The bench checks it after the following falling edge, and never before that edge.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  // Register index order is decoded by the channels: pair c sits at 2c (base), 2c+1 (limit)
  typedef enum logic [1:0] {
    SEL_FETCH_BASE  = 2'd0,
    SEL_FETCH_LIMIT = 2'd1,
    SEL_DATA_BASE   = 2'd2,
    SEL_DATA_LIMIT  = 2'd3
  } seg_sel_e;

  localparam int NUM_CHAN = 2;
  localparam int NUM_REG  = 2 * NUM_CHAN;
  localparam int SEL_W    = $clog2(NUM_REG);
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_xlate_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supervisor,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  output logic [AW-1:0]    cfg_rdata,
  input  logic             priv_err_clr,
  output logic             priv_err,
  output logic [AW-1:0]    regs_o [NUM_REG]
);

  // Named events for the checks
  logic priv_write;
  logic user_write;
  assign priv_write = cfg_we && supervisor;
  assign user_write = cfg_we && !supervisor;

  logic [AW-1:0] regs_q [NUM_REG];

  for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
    logic wen;
    assign wen = priv_write && (cfg_sel == SEL_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[i] <= '0;
      else if (wen) regs_q[i] <= cfg_wdata;
    end

    assign regs_o[i] = regs_q[i];

    assert_priv_write_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && supervisor && cfg_sel == SEL_W'(i)) |=> (regs_o[i] == $past(cfg_wdata)));

    assert_user_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !supervisor) |=> $stable(regs_o[i]));
  end

  assign cfg_rdata = supervisor ? regs_q[cfg_sel] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            priv_err <= 1'b0;
    else if (user_write)   priv_err <= 1'b1;
    else if (priv_err_clr) priv_err <= 1'b0;
  end

  assert_priv_err_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !supervisor) |=> priv_err);

  assert_priv_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_err && !priv_err_clr) |=> priv_err);

  assert_user_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !supervisor |-> (cfg_rdata == '0));

endmodule

// File: rtl/seg_chan.sv
module seg_chan #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] laddr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  output logic [AW-1:0] paddr,
  output logic          valid,
  output logic          fault
);

  function automatic logic [AW-1:0] relocate(input logic [AW-1:0] b, input logic [AW-1:0] a);
    return b + a;
  endfunction

  function automatic logic past_limit(input logic [AW-1:0] a, input logic [AW-1:0] lim);
    return a >= lim;
  endfunction

  // Named internal event: the address lies outside the segment
  logic out_of_seg;
  assign out_of_seg = past_limit(laddr, limit);

  assign paddr = relocate(base, laddr);
  assign fault = req && out_of_seg;
  assign valid = req && !out_of_seg;

  assert_fault_blocks_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && fault));

  assert_valid_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> req);

  assert_fault_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> req);

  assert_zero_limit_faults_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && limit == '0) |-> fault);

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supervisor,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic          priv_err_clr,
  output logic          priv_err,
  input  logic          if_req,
  input  logic [AW-1:0] if_laddr,
  output logic [AW-1:0] if_paddr,
  output logic          if_valid,
  output logic          if_fault,
  input  logic          dm_req,
  input  logic [AW-1:0] dm_laddr,
  output logic [AW-1:0] dm_paddr,
  output logic          dm_valid,
  output logic          dm_fault
);

  logic [AW-1:0] regs [NUM_REG];

  seg_regfile #(.AW(AW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .supervisor   (supervisor),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .priv_err_clr (priv_err_clr),
    .priv_err     (priv_err),
    .regs_o       (regs)
  );

  // Channel 0 = fetch, channel 1 = data
  logic          ch_req   [NUM_CHAN];
  logic [AW-1:0] ch_laddr [NUM_CHAN];
  logic [AW-1:0] ch_paddr [NUM_CHAN];
  logic          ch_valid [NUM_CHAN];
  logic          ch_fault [NUM_CHAN];

  assign ch_req[0]   = if_req;
  assign ch_laddr[0] = if_laddr;
  assign ch_req[1]   = dm_req;
  assign ch_laddr[1] = dm_laddr;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    seg_chan #(.AW(AW)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (ch_req[c]),
      .laddr (ch_laddr[c]),
      .base  (regs[2*c]),
      .limit (regs[2*c+1]),
      .paddr (ch_paddr[c]),
      .valid (ch_valid[c]),
      .fault (ch_fault[c])
    );
  end

  assign if_paddr = ch_paddr[0];
  assign if_valid = ch_valid[0];
  assign if_fault = ch_fault[0];
  assign dm_paddr = ch_paddr[1];
  assign dm_valid = ch_valid[1];
  assign dm_fault = ch_fault[1];

  assert_fetch_valid_in_seg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    if_valid |-> (if_laddr < regs[SEL_FETCH_LIMIT]));

  assert_data_valid_in_seg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dm_valid |-> (dm_laddr < regs[SEL_DATA_LIMIT]));

endmodule

// File: tb/sim_seg_xlate_top.sv
module sim_seg_xlate_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          supervisor = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'd0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata;
  logic          priv_err_clr = 1'b0;
  logic          priv_err;
  logic          if_req = 1'b0;
  logic [AW-1:0] if_laddr = '0;
  logic [AW-1:0] if_paddr;
  logic          if_valid, if_fault;
  logic          dm_req = 1'b0;
  logic [AW-1:0] dm_laddr = '0;
  logic [AW-1:0] dm_paddr;
  logic          dm_valid, dm_fault;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  seg_xlate_top #(.AW(AW)) u0 (.*);

  // Segment set-up used by the vector table
  localparam logic [31:0] F_BASE = 32'h0000_1000;
  localparam logic [31:0] F_LIM  = 32'h0000_0100;
  localparam logic [31:0] D_BASE = 32'h8000_0000;
  localparam logic [31:0] D_LIM  = 32'h0000_0040;

  localparam int NV = 6;
  localparam logic [NV-1:0] T_IFR = 6'b101111;
  localparam logic [NV-1:0] T_DMR = 6'b110111;
  localparam logic [NV-1:0] T_IFF = 6'b100100;
  localparam logic [NV-1:0] T_DMF = 6'b000100;
  localparam logic [31:0] T_IFA [NV] = '{32'h0, 32'hFF, 32'h100, 32'h50, 32'h0, 32'hFFFF_FFFF};
  localparam logic [31:0] T_IFP [NV] = '{32'h1000, 32'h10FF, 32'h1100, 32'h1050, 32'h1000, 32'h0FFF};
  localparam logic [31:0] T_DMA [NV] = '{32'h0, 32'h3F, 32'h40, 32'h5, 32'h10, 32'h20};
  localparam logic [31:0] T_DMP [NV] = '{32'h8000_0000, 32'h8000_003F, 32'h8000_0040,
                                         32'h8000_0005, 32'h8000_0010, 32'h8000_0020};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sup, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    supervisor = sup; cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic drive(input logic ir, input logic [31:0] ia, input logic dr, input logic [31:0] da);
    @(negedge clk);
    if_req = ir; if_laddr = ia; dm_req = dr; dm_laddr = da;
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    supervisor = 1'b1;
    #1;

    // R9: reset state
    chk("R9 priv_err after reset", {31'b0, priv_err}, 32'd0);
    for (int s = 0; s < 4; s++) begin
      cfg_sel = s[1:0]; #1;
      chk("R9 register zero after reset", cfg_rdata, 32'd0);
    end
    drive(1'b1, 32'h0, 1'b1, 32'h0);
    chk("R9 fetch faults at reset", {31'b0, if_fault}, 32'd1);
    chk("R9 fetch not valid at reset", {31'b0, if_valid}, 32'd0);
    chk("R9 data faults at reset", {31'b0, dm_fault}, 32'd1);
    chk("R9 data not valid at reset", {31'b0, dm_valid}, 32'd0);

    // R5: privileged writes, R8: read-back
    wr(1'b1, 2'd0, F_BASE);
    wr(1'b1, 2'd1, F_LIM);
    wr(1'b1, 2'd2, D_BASE);
    wr(1'b1, 2'd3, D_LIM);
    cfg_sel = 2'd0; #1; chk("R5 R8 fetch base readback", cfg_rdata, F_BASE);
    cfg_sel = 2'd1; #1; chk("R5 R8 fetch limit readback", cfg_rdata, F_LIM);
    cfg_sel = 2'd2; #1; chk("R5 R8 data base readback", cfg_rdata, D_BASE);
    cfg_sel = 2'd3; #1; chk("R5 R8 data limit readback", cfg_rdata, D_LIM);

    // Vector table: R1 R2 R3 R4 R10
    for (int k = 0; k < NV; k++) begin
      drive(T_IFR[k], T_IFA[k], T_DMR[k], T_DMA[k]);
      chk("R1 R4 fetch paddr", if_paddr, T_IFP[k]);
      chk("R2 fetch fault", {31'b0, if_fault}, {31'b0, T_IFF[k]});
      chk("R3 R10 fetch valid", {31'b0, if_valid}, {31'b0, T_IFR[k] & ~T_IFF[k]});
      chk("R1 R4 data paddr", dm_paddr, T_DMP[k]);
      chk("R2 data fault", {31'b0, dm_fault}, {31'b0, T_DMF[k]});
      chk("R3 R10 data valid", {31'b0, dm_valid}, {31'b0, T_DMR[k] & ~T_DMF[k]});
    end

    // R8: user-mode read gives zero
    supervisor = 1'b0; cfg_sel = 2'd2; #1;
    chk("R8 user read zero", cfg_rdata, 32'd0);

    // R6 R7: user write ignored, flag set
    chk("R7 flag clear before", {31'b0, priv_err}, 32'd0);
    wr(1'b0, 2'd1, 32'h0000_0001);
    chk("R7 flag set after user write", {31'b0, priv_err}, 32'd1);
    drive(1'b1, 32'h80, 1'b0, 32'h0);
    chk("R6 fetch limit unchanged (0x80 still valid)", {31'b0, if_valid}, 32'd1);
    chk("R6 fetch paddr unchanged", if_paddr, 32'h1080);
    supervisor = 1'b1; cfg_sel = 2'd1; #1;
    chk("R6 fetch limit readback unchanged", cfg_rdata, F_LIM);
    @(negedge clk); #1;
    chk("R7 flag sticky", {31'b0, priv_err}, 32'd1);

    // R7: clear, then set wins over clear
    @(negedge clk); priv_err_clr = 1'b1;
    @(negedge clk); priv_err_clr = 1'b0; #1;
    chk("R7 flag cleared", {31'b0, priv_err}, 32'd0);
    @(negedge clk);
    supervisor = 1'b0; cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h5; priv_err_clr = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; priv_err_clr = 1'b0; supervisor = 1'b1; #1;
    chk("R7 set wins over clear", {31'b0, priv_err}, 32'd1);
    cfg_sel = 2'd0; #1;
    chk("R6 fetch base unchanged", cfg_rdata, F_BASE);

    // R1: wraparound on the data channel; R4 fetch unaffected
    wr(1'b1, 2'd2, 32'hFFFF_FFF0);
    wr(1'b1, 2'd3, 32'hFFFF_FFFF);
    drive(1'b1, 32'h10, 1'b1, 32'h20);
    chk("R1 data wraparound paddr", dm_paddr, 32'h0000_0010);
    chk("R3 data valid wide limit", {31'b0, dm_valid}, 32'd1);
    chk("R4 fetch unaffected by data pair", if_paddr, 32'h1010);
    chk("R4 fetch still valid", {31'b0, if_valid}, 32'd1);

    // R2: limit boundary on new data limit
    drive(1'b0, 32'h0, 1'b1, 32'hFFFF_FFFE);
    chk("R2 limit minus one ok", {31'b0, dm_fault}, 32'd0);
    drive(1'b0, 32'h0, 1'b1, 32'hFFFF_FFFF);
    chk("R2 equal to limit faults", {31'b0, dm_fault}, 32'd1);
    chk("R10 idle fetch no fault", {31'b0, if_fault}, 32'd0);
    chk("R10 idle fetch no valid", {31'b0, if_valid}, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule